// File: doc/BRIEF.md
# Time-of-Day Clock with Alarm and Stopwatch

This block keeps a 24-hour time of day, an alarm time and a stopwatch, all stepped from one shared divider of the system clock. At the default setting the divider gives a hundredths-of-a-second tick every 500,000 cycles of a 50 MHz clock. Every hundredth such tick is a one-second tick. The time of day counts in BCD as HH:MM:SS. A set mode holds the clock and lets the user step hours or minutes. The alarm lights an LED, blinking once per second for one minute, when the time reaches the stored alarm HH:MM. The stopwatch counts MM:SS.hh and keeps its value when stopped.

Buttons are expected to arrive debounced, as single-cycle pulses. The output is six BCD digits for whichever view is selected, plus the alarm LED. Seven-segment decoding and display multiplexing belong to the logic that uses this block.

Top module: `tod_clock`

## Requirements
- R1: After reset the time, the alarm time and the stopwatch read all zeros, the LED is off, the stopwatch is stopped, and the field selection points at hours.
- R2: Outside set mode the seconds advance once every 100*TICKS_PER_CS cycles, counting 00 to 59 in BCD. The seconds carry into minutes (00 to 59), and minutes carry into hours (00 to 23, then 00). Every carry takes effect on the same clock edge.
- R3: While set_mode is high the time does not advance and the seconds read 00. Each inc_btn pulse adds one to the selected field only: hours wrap from 23 to 00, minutes wrap from 59 to 00, and there is no carry into the other field.
- R4: Each field_btn pulse toggles the selected field between hours and minutes. The same selection applies when editing the time and when editing the alarm.
- R5: With alarm_mode high and set_mode low, the display shows the alarm as HH MM 00, and inc_btn edits the selected alarm field with the same wrap rules as R3.
- R6: Ringing starts on the edge where the running time becomes alarm HH:MM:00. While ringing, the LED is lit during hundredths 00 to 49 of each second. Ringing lasts 60 one-second ticks.
- R7: Any button pulse (field_btn, inc_btn, sw_startstop, sw_clear) stops the ringing, and the LED is dark from the next edge.
- R8: Each sw_startstop pulse toggles the stopwatch between running and stopped. While running it adds one hundredth every TICKS_PER_CS cycles. A stopped stopwatch keeps its value, and a restart continues from that value.
- R9: Stopwatch hundredths carry 99 to 00 into seconds, and seconds carry 59 to 00 into minutes. The stopwatch rolls from 59:59.99 to 00:00.00.
- R10: sw_clear zeroes the stopwatch only while it is stopped. While it runs, sw_clear has no effect.
- R11: The digits output holds {d5,d4,d3,d2,d1,d0} with d5 in bits 23:20. When sw_view is high it shows stopwatch MM SS hh. Otherwise, if alarm mode applies it shows the alarm. Otherwise it shows the time HH MM SS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_mode | input | 1 | Level: hold the time and edit it |
| alarm_mode | input | 1 | Level: show and edit the alarm time |
| sw_view | input | 1 | Level: show the stopwatch |
| field_btn | input | 1 | Pulse: toggle hours/minutes selection |
| inc_btn | input | 1 | Pulse: step the selected field |
| sw_startstop | input | 1 | Pulse: start or stop the stopwatch |
| sw_clear | input | 1 | Pulse: zero a stopped stopwatch |
| digits | output | 24 | Six BCD digits of the selected view |
| alarm_led | output | 1 | Blinking alarm indicator |

## Verification
Counting the first clock edge after reset release as edge 1, hundredth ticks land on edges that are multiples of TICKS_PER_CS, and second ticks land on multiples of 100*TICKS_PER_CS. The time digits and the LED change on those very edges. Button effects show after the single edge that captures the pulse. The stopwatch gains exactly K hundredths when its start and stop pulses are captured K*TICKS_PER_CS edges apart. The bench counts edges from reset and computes each due edge arithmetically. It samples at the falling edge just after that edge, and for the alarm it also samples one edge before to catch early changes.

// File: rtl/tod_pkg.sv
// Shared types and BCD arithmetic for the time-of-day clock.
// Assumes every BCD byte holds two valid decimal digits.
package tod_pkg;

    typedef logic [7:0] bcd8_t;

    typedef struct packed {
        bcd8_t hr;
        bcd8_t mn;
        bcd8_t sc;
    } hms_t;

    // Two-digit BCD increment that wraps to 00 after the given last value.
    function automatic bcd8_t bcd_step(input bcd8_t v, input bcd8_t last);
        if (v == last)
            return 8'h00;
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/tod_prescale.sv
// Divides the system clock into a hundredths tick and a seconds tick.
// Also exposes the hundredths phase (0..99) for blink timing.
// Assumes TICKS_PER_CS >= 1. A value of 1 ticks on every cycle.
module tod_prescale #(
    parameter int unsigned TICKS_PER_CS = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       tick_cs,
    output logic       tick_s,
    output logic [6:0] cs_q
);

    generate
        if (TICKS_PER_CS <= 1) begin : g_direct
            assign tick_cs = 1'b1;
        end else begin : g_count
            localparam int unsigned PW = $clog2(TICKS_PER_CS);
            logic [PW-1:0] div_q;

            // Cycle divider that restarts at each hundredths tick.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    div_q <= '0;
                else if (tick_cs)
                    div_q <= '0;
                else
                    div_q <= div_q + PW'(1);
            end

            assign tick_cs = (div_q == PW'(TICKS_PER_CS - 1));
        end
    endgenerate

    // Hundredths phase within the current second.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cs_q <= '0;
        else if (tick_cs)
            cs_q <= (cs_q == 7'd99) ? 7'd0 : cs_q + 7'd1;
    end

    assign tick_s = tick_cs && (cs_q == 7'd99);

endmodule

// File: rtl/tod_timekeep.sv
// Holds HH:MM:SS in BCD. Outside set mode it advances on the seconds tick
// with a full carry chain. In set mode it freezes, holds the seconds at 00
// and steps one field per inc pulse. Exposes the next-state value so that
// the alarm can match on the same edge.
module tod_timekeep
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_s,
    input  logic set_mode,
    input  logic inc_btn,
    input  logic field_min,
    output hms_t now_q,
    output hms_t now_d,
    output logic adv
);

    // Next-state logic for the time of day.
    always_comb begin
        now_d = now_q;
        adv   = 1'b0;
        if (set_mode) begin
            now_d.sc = 8'h00;
            if (inc_btn) begin
                if (field_min)
                    now_d.mn = bcd_step(now_q.mn, 8'h59);
                else
                    now_d.hr = bcd_step(now_q.hr, 8'h23);
            end
        end else if (tick_s) begin
            adv      = 1'b1;
            now_d.sc = bcd_step(now_q.sc, 8'h59);
            if (now_q.sc == 8'h59) begin
                now_d.mn = bcd_step(now_q.mn, 8'h59);
                if (now_q.mn == 8'h59)
                    now_d.hr = bcd_step(now_q.hr, 8'h23);
            end
        end
    end

    // Time-of-day register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            now_q <= '0;
        else
            now_q <= now_d;
    end

endmodule

// File: rtl/tod_alarm.sv
// Stores the alarm HH:MM and runs the ringing window. Ringing starts when
// the advancing time becomes HH:MM:00 equal to the alarm and lasts
// RING_SECS seconds. Any button cancels it. The LED is lit during the first
// BLINK_ON hundredths of each second while ringing.
module tod_alarm
    import tod_pkg::*;
#(
    parameter int unsigned RING_SECS = 60,
    parameter int unsigned BLINK_ON  = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edit_en,
    input  logic       inc_btn,
    input  logic       field_min,
    input  logic       adv,
    input  hms_t       now_d,
    input  logic       tick_s,
    input  logic       cancel,
    input  logic [6:0] cs_q,
    output bcd8_t      al_hr,
    output bcd8_t      al_mn,
    output logic       ring_start,
    output logic       led
);

    localparam int unsigned RW = $clog2(RING_SECS + 1);

    logic [RW-1:0] ring_cnt;

    // Alarm time register, stepped one field at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_hr <= 8'h00;
            al_mn <= 8'h00;
        end else if (edit_en && inc_btn) begin
            if (field_min)
                al_mn <= bcd_step(al_mn, 8'h59);
            else
                al_hr <= bcd_step(al_hr, 8'h23);
        end
    end

    assign ring_start = adv && (now_d.sc == 8'h00) &&
                        (now_d.hr == al_hr) && (now_d.mn == al_mn);

    // Seconds left in the ringing window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ring_cnt <= '0;
        else if (ring_start)
            ring_cnt <= RW'(RING_SECS);
        else if (cancel)
            ring_cnt <= '0;
        else if (tick_s && (ring_cnt != '0))
            ring_cnt <= ring_cnt - RW'(1);
    end

    assign led = (ring_cnt != '0) && (cs_q < 7'(BLINK_ON));

endmodule

// File: rtl/tod_stopwatch.sv
// MM:SS.hh stopwatch in BCD. A start/stop pulse toggles running. While
// running it counts one hundredth per tick and rolls over after 59:59.99.
// Clear acts only while the stopwatch is stopped.
module tod_stopwatch
    import tod_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_cs,
    input  logic  start_stop,
    input  logic  clear,
    output logic  run,
    output bcd8_t sw_mm,
    output bcd8_t sw_ss,
    output bcd8_t sw_hh
);

    // Run flag and counting chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            sw_mm <= 8'h00;
            sw_ss <= 8'h00;
            sw_hh <= 8'h00;
        end else begin
            if (start_stop)
                run <= !run;
            if (run) begin
                if (tick_cs) begin
                    sw_hh <= bcd_step(sw_hh, 8'h99);
                    if (sw_hh == 8'h99) begin
                        sw_ss <= bcd_step(sw_ss, 8'h59);
                        if (sw_ss == 8'h59)
                            sw_mm <= bcd_step(sw_mm, 8'h59);
                    end
                end
            end else if (clear) begin
                sw_mm <= 8'h00;
                sw_ss <= 8'h00;
                sw_hh <= 8'h00;
            end
        end
    end

endmodule

// File: rtl/tod_clock.sv
// Top level: a shared divider feeds the time of day, the alarm and the
// stopwatch. The output is six BCD digits of the chosen view plus the alarm
// LED. Buttons are assumed debounced single-cycle pulses.
module tod_clock
    import tod_pkg::*;
#(
    parameter int unsigned TICKS_PER_CS = 500000,
    parameter int unsigned RING_SECS    = 60,
    parameter int unsigned BLINK_ON     = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_mode,
    input  logic        alarm_mode,
    input  logic        sw_view,
    input  logic        field_btn,
    input  logic        inc_btn,
    input  logic        sw_startstop,
    input  logic        sw_clear,
    output logic [23:0] digits,
    output logic        alarm_led
);

    logic       tick_cs;
    logic       tick_s;
    logic [6:0] cs_q;
    logic       field_min;
    logic       adv;
    logic       ring_start;
    logic       sw_run;
    hms_t       now_q;
    hms_t       now_d;
    bcd8_t      al_hr;
    bcd8_t      al_mn;
    bcd8_t      sw_mm;
    bcd8_t      sw_ss;
    bcd8_t      sw_hh;
    logic       alarm_edit;
    logic       any_btn;

    assign alarm_edit = alarm_mode && !set_mode;
    assign any_btn    = field_btn || inc_btn || sw_startstop || sw_clear;

    // Hours/minutes field selection shared by time and alarm editing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            field_min <= 1'b0;
        else if (field_btn)
            field_min <= !field_min;
    end

    tod_prescale #(.TICKS_PER_CS(TICKS_PER_CS)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_cs (tick_cs),
        .tick_s  (tick_s),
        .cs_q    (cs_q)
    );

    tod_timekeep u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_s    (tick_s),
        .set_mode  (set_mode),
        .inc_btn   (inc_btn),
        .field_min (field_min),
        .now_q     (now_q),
        .now_d     (now_d),
        .adv       (adv)
    );

    tod_alarm #(.RING_SECS(RING_SECS), .BLINK_ON(BLINK_ON)) u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .edit_en    (alarm_edit),
        .inc_btn    (inc_btn),
        .field_min  (field_min),
        .adv        (adv),
        .now_d      (now_d),
        .tick_s     (tick_s),
        .cancel     (any_btn),
        .cs_q       (cs_q),
        .al_hr      (al_hr),
        .al_mn      (al_mn),
        .ring_start (ring_start),
        .led        (alarm_led)
    );

    tod_stopwatch u_sw (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_cs    (tick_cs),
        .start_stop (sw_startstop),
        .clear      (sw_clear),
        .run        (sw_run),
        .sw_mm      (sw_mm),
        .sw_ss      (sw_ss),
        .sw_hh      (sw_hh)
    );

    // View selection: stopwatch, then alarm, then time of day.
    always_comb begin
        if (sw_view)
            digits = {sw_mm, sw_ss, sw_hh};
        else if (alarm_edit)
            digits = {al_hr, al_mn, 8'h00};
        else
            digits = {now_q.hr, now_q.mn, now_q.sc};
    end

endmodule

// File: rtl/tod_clock_chk.sv
// Property checker for tod_clock, attached through bind below.
module tod_clock_chk
    import tod_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  set_mode,
    input logic  field_btn,
    input logic  inc_btn,
    input logic  sw_startstop,
    input logic  sw_clear,
    input logic  tick_s,
    input logic  tick_cs,
    input hms_t  now_q,
    input bcd8_t al_hr,
    input bcd8_t al_mn,
    input logic  alarm_led,
    input logic  ring_start,
    input logic  sw_run,
    input bcd8_t sw_mm,
    input bcd8_t sw_ss,
    input bcd8_t sw_hh
);

    logic        btn_any;
    logic [23:0] sw_val;

    assign btn_any = field_btn || inc_btn || sw_startstop || sw_clear;
    assign sw_val  = {sw_mm, sw_ss, sw_hh};

    // R2: time fields stay in their BCD ranges
    a_r2_time_range: assert property (@(posedge clk) disable iff (!rst_n)
        (now_q.hr <= 8'h23) && (now_q.mn <= 8'h59) && (now_q.sc <= 8'h59) &&
        (now_q.hr[3:0] <= 4'd9) && (now_q.mn[3:0] <= 4'd9) && (now_q.sc[3:0] <= 4'd9));

    // R2: seconds change only after a seconds tick when not setting
    a_r2_sec_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(now_q.sc) && !$past(set_mode)) |-> $past(tick_s));

    // R2: an hour change while running lands on MM:SS = 00:00
    a_r2_hour_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(now_q.hr) && !$past(set_mode)) |-> (now_q.mn == 8'h00 && now_q.sc == 8'h00));

    // R3: set mode holds seconds at 00
    a_r3_set_clears_sec: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode |=> (now_q.sc == 8'h00));

    // R6: LED lit only while the time is inside the alarm minute
    a_r6_led_in_minute: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_led |-> (now_q.hr == al_hr && now_q.mn == al_mn));

    // R7: a button ends the ringing
    a_r7_button_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_any && !ring_start) |=> !alarm_led);

    // R8: a stopped stopwatch keeps its value unless cleared
    a_r8_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_run && !sw_clear) |=> $stable(sw_val));

    // R9: rollover from 59:59.99 to zero
    a_r9_sw_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_run && tick_cs && sw_val == 24'h595999) |=> (sw_val == 24'h000000));

    // R10: while running, only a tick changes the value (clear ignored)
    a_r10_clear_ignored_running: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_run && !tick_cs) |=> $stable(sw_val));

endmodule

bind tod_clock tod_clock_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_mode     (set_mode),
    .field_btn    (field_btn),
    .inc_btn      (inc_btn),
    .sw_startstop (sw_startstop),
    .sw_clear     (sw_clear),
    .tick_s       (tick_s),
    .tick_cs      (tick_cs),
    .now_q        (now_q),
    .al_hr        (al_hr),
    .al_mn        (al_mn),
    .alarm_led    (alarm_led),
    .ring_start   (ring_start),
    .sw_run       (sw_run),
    .sw_mm        (sw_mm),
    .sw_ss        (sw_ss),
    .sw_hh        (sw_hh)
);

// File: tb/tod_clock_test.sv
`timescale 1ns/1ps
module tod_clock_test;

    localparam int T = 2;          // cycles per hundredth in this bench
    localparam int S = 100 * T;    // cycles per second
    localparam int B_FIELD = 0;
    localparam int B_INC   = 1;
    localparam int B_SS    = 2;
    localparam int B_CLR   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_mode = 1'b0;
    logic        alarm_mode = 1'b0;
    logic        sw_view = 1'b0;
    logic        field_btn = 1'b0;
    logic        inc_btn = 1'b0;
    logic        sw_startstop = 1'b0;
    logic        sw_clear = 1'b0;
    logic [23:0] digits;
    logic        alarm_led;

    int tests = 0;
    int fails = 0;
    int edges = 0;
    bit done = 1'b0;

    tod_clock #(.TICKS_PER_CS(T)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_mode     (set_mode),
        .alarm_mode   (alarm_mode),
        .sw_view      (sw_view),
        .field_btn    (field_btn),
        .inc_btn      (inc_btn),
        .sw_startstop (sw_startstop),
        .sw_clear     (sw_clear),
        .digits       (digits),
        .alarm_led    (alarm_led)
    );

    always #2 clk = ~clk;

    // Edge 1 is the first rising edge with reset released.
    always @(posedge clk) if (rst_n) edges <= edges + 1;

    function automatic logic [7:0] bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic logic [23:0] hms(input int secs);
        int s;
        s = secs % 86400;
        return {bcd(s / 3600), bcd((s / 60) % 60), bcd(s % 60)};
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at edge %0d", req, act, exp, edges);
        end
    endtask

    task automatic press(input int which);
        case (which)
            B_FIELD: field_btn = 1'b1;
            B_INC:   inc_btn = 1'b1;
            B_SS:    sw_startstop = 1'b1;
            default: sw_clear = 1'b1;
        endcase
        @(negedge clk);
        field_btn = 1'b0;
        inc_btn = 1'b0;
        sw_startstop = 1'b0;
        sw_clear = 1'b0;
    endtask

    task automatic wait_edge(input int n);
        while (edges < n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d expected done", edges);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int c;
        int e;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 digits", digits, 24'h000000);
        chk("R1 led", {23'd0, alarm_led}, 24'd0);

        // R3 and R4: exhaustive hour stepping, then minute stepping
        set_mode = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 24; k++) begin
            press(B_INC);
            chk("R3 hour step", digits, {bcd(k % 24), 8'h00, 8'h00});
        end
        press(B_FIELD);
        for (int k = 1; k <= 60; k++) begin
            press(B_INC);
            chk("R3 minute step no carry", digits, {8'h00, bcd(k % 60), 8'h00});
        end
        press(B_FIELD);
        repeat (23) press(B_INC);
        press(B_FIELD);
        repeat (59) press(B_INC);
        chk("R4 fields set", digits, 24'h235900);

        // R2: one-second steps through the full carry into 00:00:00
        set_mode = 1'b0;
        c = edges;
        for (int k = 1; k <= 60; k++) begin
            e = (c / S + k) * S;
            if (k == 1) begin
                wait_edge(e - 1);
                chk("R2 not early", digits, 24'h235900);
            end
            wait_edge(e);
            chk("R2 second step", digits, hms(23 * 3600 + 59 * 60 + k));
        end
        wait_edge(e + 5 * S + 3);
        chk("R2 after wrap", digits, 24'h000005);

        // R3: entering set mode clears seconds and freezes
        set_mode = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 seconds cleared", digits, 24'h000000);
        wait_edge(edges + 3 * S);
        chk("R3 frozen", digits, 24'h000000);
        set_mode = 1'b0;
        c = edges;

        // R5: alarm view and editing (field currently minutes)
        alarm_mode = 1'b1;
        @(negedge clk);
        chk("R5 alarm reset view", digits, 24'h000000);
        press(B_FIELD);
        repeat (5) press(B_INC);
        chk("R5 alarm hour", digits, 24'h050000);
        repeat (19) press(B_INC);
        chk("R5 alarm hour wrap", digits, 24'h000000);
        press(B_FIELD);
        press(B_INC);
        chk("R5 alarm minute", digits, 24'h000100);
        alarm_mode = 1'b0;
        @(negedge clk);
        chk("R11 time view back", digits, hms(edges / S - c / S));

        // R6: ringing window and blink phase
        e = (c / S + 60) * S;
        wait_edge(e - 1);
        chk("R6 not early", {23'd0, alarm_led}, 24'd0);
        wait_edge(e);
        chk("R6 start led", {23'd0, alarm_led}, 24'd1);
        chk("R6 start time", digits, 24'h000100);
        wait_edge(e + 50 * T - 1);
        chk("R6 last lit hundredth", {23'd0, alarm_led}, 24'd1);
        wait_edge(e + 50 * T);
        chk("R6 dark half", {23'd0, alarm_led}, 24'd0);
        wait_edge(e + S);
        chk("R6 second blink", {23'd0, alarm_led}, 24'd1);
        wait_edge(e + 59 * S + 49 * T);
        chk("R6 last blink", {23'd0, alarm_led}, 24'd1);
        wait_edge(e + 60 * S);
        chk("R6 window over", {23'd0, alarm_led}, 24'd0);

        // R7: a button cancels ringing
        alarm_mode = 1'b1;
        @(negedge clk);
        press(B_INC);
        press(B_INC);
        chk("R5 alarm 00:03", digits, 24'h000300);
        alarm_mode = 1'b0;
        e = (c / S + 180) * S;
        wait_edge(e);
        chk("R7 ringing", {23'd0, alarm_led}, 24'd1);
        wait_edge(e + 3 * S);
        chk("R7 still ringing", {23'd0, alarm_led}, 24'd1);
        press(B_INC);
        chk("R7 cancelled", {23'd0, alarm_led}, 24'd0);
        chk("R7 time untouched", digits, 24'h000303);
        wait_edge(e + 4 * S);
        chk("R7 stays dark", {23'd0, alarm_led}, 24'd0);

        // R8 to R11: stopwatch
        sw_view = 1'b1;
        alarm_mode = 1'b1;
        @(negedge clk);
        chk("R11 stopwatch view priority", digits, 24'h000000);
        press(B_SS);
        repeat (150 * T - 1) @(negedge clk);
        press(B_SS);
        chk("R8 run 1.50 s", digits, 24'h000150);
        repeat (40) @(negedge clk);
        chk("R8 stopped holds", digits, 24'h000150);
        press(B_SS);
        repeat (10 * T - 1) @(negedge clk);
        press(B_CLR);
        repeat (27 * T - 1) @(negedge clk);
        press(B_SS);
        chk("R10 clear ignored while running", digits, 24'h000187);
        press(B_CLR);
        chk("R10 clear when stopped", digits, 24'h000000);
        press(B_SS);
        repeat (6001 * T - 1) @(negedge clk);
        press(B_SS);
        chk("R9 minute carry", digits, 24'h010001);
        sw_view = 1'b0;
        @(negedge clk);
        chk("R11 alarm view", digits, 24'h000300);
        alarm_mode = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule